// File: doc/BRIEF.md
# Integer Adder with Carry, Overflow and Range-Exception Output

This block is the add unit of a RISC execute stage. Each cycle in which `in_valid` is high it adds two two's-complement operands. One clock later it presents the registered sum together with two status flags.

The carry flag is found by an unsigned compare of the sum against the first operand. The overflow flag is found from the signs of the two operands and the sign of the sum. Both flags are rewritten on every add. Between adds they keep their last value.

When the overflow-exception enable input is high and the new overflow flag is set, the unit raises a range-exception request. This request is a one-cycle pulse that lines up with the result strobe. Routing the exception to a handler is left to the surrounding pipeline. The sum is always written, including when an overflow occurs.

Top module: `add_flag_unit`

## Requirements
- R1: One clock after an add is accepted, `sum` equals `(opa + opb) mod 2^W`.
- R2: `out_valid` is high for exactly the cycle after each cycle in which `in_valid` was high, and low otherwise.
- R3: After an add, `ovf` is 1 when both operands have the same sign bit (bit W-1) and the sum's sign bit differs from it. Otherwise `ovf` is 0.
- R4: After an add, `carry` is 1 when the sum, read as unsigned, is less than `opa`. Otherwise `carry` is 0. This matches the carry-out of the W-bit add.
- R5: `range_exc` is high only in a cycle where `out_valid` is high, and then it equals (`ove_en` sampled with the add) AND the new `ovf`.
- R6: The sum is written to `sum` even when the add overflows.
- R7: In cycles without an add, `sum`, `carry` and `ovf` hold their previous values and `range_exc` stays low.
- R8: `ovf` is updated even when `ove_en` is 0.
- R9: While synchronous reset is high, and in the first cycle after it, `sum`, `carry`, `ovf`, `out_valid` and `range_exc` are all 0.
- R10: An add that has neither carry nor overflow clears both flags, even if they were set by an earlier add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe for one add |
| opa | input | W | First operand, two's complement |
| opb | input | W | Second operand, two's complement |
| ove_en | input | 1 | Overflow-exception enable from the status register |
| out_valid | output | 1 | Result strobe, one cycle after the issue |
| sum | output | W | Registered sum |
| carry | output | 1 | Unsigned carry flag |
| ovf | output | 1 | Signed overflow flag |
| range_exc | output | 1 | One-cycle range-exception request |

## Verification
The bound checker checks four things on every cycle, against the operands sampled one cycle earlier:
- the strobe timing;
- the sum, carry and overflow values;
- the gating of the exception by the enable and the overflow flag;
- the holding of the outputs between adds.

Only the bench's scenarios can show the following:
- that flags set by an earlier add are cleared by a clean one;
- that an overflow with the enable low still updates the flag and raises no pulse;
- that the boundary sums near the most-positive and most-negative values produce the right pattern of flags.

// File: rtl/add_flag_pkg.sv
package add_flag_pkg;

    typedef struct packed {
        logic cy;
        logic ov;
    } add_flags_t;

    // Signed overflow from the three sign bits.
    function automatic logic sign_overflow(input logic a_s, input logic b_s, input logic r_s);
        return (a_s == b_s) && (r_s != a_s);
    endfunction

endpackage

// File: rtl/add_core.sv
module add_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s,
    output logic         cy
);
    always_comb begin
        s  = a + b;
        // Unsigned wrap-around leaves the sum below the first operand.
        cy = (s < a);
    end
endmodule

// File: rtl/ovf_detect.sv
module ovf_detect
    import add_flag_pkg::*;
(
    input  logic a_msb,
    input  logic b_msb,
    input  logic s_msb,
    output logic ov
);
    always_comb ov = sign_overflow(a_msb, b_msb, s_msb);
endmodule

// File: rtl/status_reg.sv
module status_reg
    import add_flag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [W-1:0] d_sum,
    input  add_flags_t d_flags,
    input  logic       d_exc,
    output logic [W-1:0] q_sum,
    output add_flags_t q_flags,
    output logic       q_valid,
    output logic       q_exc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_sum   <= '0;
            q_flags <= '0;
            q_valid <= 1'b0;
            q_exc   <= 1'b0;
        end else begin
            q_valid <= load;
            q_exc   <= load & d_exc;
            if (load) begin
                q_sum   <= d_sum;
                q_flags <= d_flags;
            end
        end
    end
endmodule

// File: rtl/add_flag_unit.sv
module add_flag_unit
    import add_flag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         ove_en,
    output logic         out_valid,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf,
    output logic         range_exc
);
    localparam int MSB = W - 1;

    logic [W-1:0] raw_sum;
    logic         raw_cy;
    logic         raw_ov;
    logic         exc_req;
    add_flags_t   nxt_flags;
    add_flags_t   cur_flags;

    add_core #(.W(W)) u_core (
        .a  (opa),
        .b  (opb),
        .s  (raw_sum),
        .cy (raw_cy)
    );

    ovf_detect u_ovf (
        .a_msb (opa[MSB]),
        .b_msb (opb[MSB]),
        .s_msb (raw_sum[MSB]),
        .ov    (raw_ov)
    );

    always_comb begin
        nxt_flags.cy = raw_cy;
        nxt_flags.ov = raw_ov;
        // The exception is gated by the new overflow; the flag itself is always written.
        exc_req      = ove_en & raw_ov;
    end

    status_reg #(.W(W)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .d_sum   (raw_sum),
        .d_flags (nxt_flags),
        .d_exc   (exc_req),
        .q_sum   (sum),
        .q_flags (cur_flags),
        .q_valid (out_valid),
        .q_exc   (range_exc)
    );

    assign carry = cur_flags.cy;
    assign ovf   = cur_flags.ov;
endmodule

// File: rtl/add_flag_unit_chk.sv
module add_flag_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         ove_en,
    input logic         out_valid,
    input logic [W-1:0] sum,
    input logic         carry,
    input logic         ovf,
    input logic         range_exc
);
    p_sum_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (sum == $past(opa) + $past(opb)));

    p_valid_on_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_off_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (ovf == (($past(opa[W-1]) == $past(opb[W-1])) &&
                              (sum[W-1] != $past(opa[W-1])))));

    p_carry_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (carry == (sum < $past(opa))));

    p_exc_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
        range_exc |-> (out_valid && ovf));

    p_exc_gate_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (range_exc == ($past(ove_en) && ovf)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(sum) && $stable(carry) && $stable(ovf) && !range_exc));
endmodule

bind add_flag_unit add_flag_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opa       (opa),
    .opb       (opb),
    .ove_en    (ove_en),
    .out_valid (out_valid),
    .sum       (sum),
    .carry     (carry),
    .ovf       (ovf),
    .range_exc (range_exc)
);

// File: tb/add_flag_unit_test.sv
module add_flag_unit_test;
    localparam int  W      = 32;
    localparam time CLK_T  = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         ove_en = 1'b0;
    logic         out_valid;
    logic [W-1:0] sum;
    logic         carry;
    logic         ovf;
    logic         range_exc;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    typedef struct {
        logic [W-1:0] s;
        logic         cy;
        logic         ov;
        logic         exc;
        logic         en;
    } exp_t;

    exp_t sb[$];

    add_flag_unit #(.W(W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
        .ove_en(ove_en), .out_valid(out_valid), .sum(sum), .carry(carry),
        .ovf(ovf), .range_exc(range_exc)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: one add per call, expected values from the requirements.
    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic en);
        exp_t e;
        logic [W:0] wide;
        @(negedge clk);
        opa = a; opb = b; ove_en = en; in_valid = 1'b1;
        wide  = {1'b0, a} + {1'b0, b};
        e.s   = wide[W-1:0];
        e.cy  = wide[W];
        e.ov  = (a[W-1] == b[W-1]) && (e.s[W-1] != a[W-1]);
        e.exc = en && e.ov;
        e.en  = en;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opa = $urandom; opb = $urandom; ove_en = 1'b1;
        end
    endtask

    // Monitor: samples a quarter period after each rising edge.
    logic [W-1:0] last_s  = '0;
    logic         last_cy = 1'b0;
    logic         last_ov = 1'b0;
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_T/4);
            if (running) begin
                if (out_valid) begin
                    exp_t e;
                    if (sb.size() == 0) begin
                        chk(1'b0, "R2 unexpected out_valid", 1, 0);
                    end else begin
                        e = sb.pop_front();
                        chk(sum == e.s, e.ov ? "R6 sum on overflow" : "R1 sum", sum, e.s);
                        chk(carry == e.cy, "R4 carry", carry, e.cy);
                        chk(ovf == e.ov, e.en ? "R3 ovf" : "R8 ovf with enable low", ovf, e.ov);
                        chk(range_exc == e.exc, "R5 range_exc", range_exc, e.exc);
                        if (!e.cy && !e.ov)
                            chk(!carry && !ovf, "R10 flags cleared", {carry, ovf}, 0);
                    end
                    last_s = sum; last_cy = carry; last_ov = ovf;
                end else begin
                    chk(sb.size() == 0, "R2 missing out_valid", 0, 1);
                    chk(sum == last_s && carry == last_cy && ovf == last_ov,
                        "R7 hold", {carry, ovf}, {last_cy, last_ov});
                    chk(!range_exc, "R7 no pulse while idle", range_exc, 0);
                end
            end
        end
    end

    initial begin
        #(CLK_T * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] x;
        repeat (3) @(negedge clk);
        chk(!out_valid && sum == '0 && !carry && !ovf && !range_exc,
            "R9 outputs during reset", {out_valid, carry, ovf, range_exc}, 0);
        rst = 1'b0;
        @(posedge clk); #(CLK_T/4);
        chk(!out_valid && sum == '0 && !carry && !ovf && !range_exc,
            "R9 outputs after reset", {out_valid, carry, ovf, range_exc}, 0);
        running = 1'b1;

        issue(32'd1, 32'd2, 1'b1);                 // plain add
        idle(2);
        issue(32'h7FFF_FFFF, 32'd1, 1'b1);         // positive overflow, exception
        idle(1);
        issue(32'h0000_0005, 32'h0000_0003, 1'b1); // clears flags
        issue(32'h8000_0000, 32'h8000_0000, 1'b0); // overflow + carry, enable low
        issue(32'hFFFF_FFFF, 32'd1, 1'b1);         // carry only, sum zero
        issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1); // carry, no overflow
        issue(32'h8000_0000, 32'hFFFF_FFFF, 1'b1); // negative overflow
        issue(32'd10, 32'hFFFF_FFF6, 1'b0);        // sum zero with carry
        issue(32'd0, 32'd0, 1'b1);                 // all clear
        idle(3);
        x = 32'h1234_5678;
        for (int i = 0; i < 40; i++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            issue(x, x ^ 32'h9E37_79B9, i[0]);
            if (i % 5 == 0) idle(1);
        end
        idle(3);
        chk(sb.size() == 0, "R2 all results seen", sb.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule